// File: doc/BRIEF.md
# Privileged Processor Control Register File

This block holds the processor status word and two 3-bit alternate address-space code registers, one for the source side and one for the destination side of a cross-space move. An execution unit reaches them through a single request port. Each request carries a register select, a read/write direction, the privilege level of the requesting code, and a flag that narrows a status access to its condition-code byte. Reads return data with every undefined bit forced to zero. Writes change only the defined fields. The ALU has its own port for loading fresh condition flags.

Each register has its own privilege rule. At user level only the condition-code byte of the status word may be touched. The full status word and both code registers are supervisor-only. A user-level attempt on them is refused: it changes nothing, returns zero, and raises a one-cycle privilege-fault pulse. The interrupt mask, trace mode, supervisor bit and condition flags are driven out continuously so that other logic can use them.

Top module: `ctrl_regfile`

## Requirements
- R1: While rst_n is low and on release, super_bit is 1, int_mask is 3'b111, trace_mode is 2'b00, cc_flags is 0 and both code registers hold 0.
- R2: The status word layout is: trace mode in bits 15:14, supervisor bit in bit 13, interrupt mask in bits 10:8, and flags X,N,Z,V,C in bits 4:0 (X at bit 4, C at bit 0). A supervisor full-word read (req_sel=0, req_ccr_only=0) returns this word zero-extended to 32 bits. A supervisor full-word write loads all of these fields on the next clock edge.
- R3: Status bits 12:11 and 7:5 always read as zero, and writes to them have no effect. So do bits 31:16 of any read.
- R4: A condition-code access (req_sel=0, req_ccr_only=1) is allowed at either privilege level. It reads bits 15:8 as zero, and on a write it loads only bits 4:0, discarding the upper byte.
- R5: A user-level (req_super=0) request for the full status word or for either code register, read or write, returns zero on rd_data and leaves every register unchanged. One cycle later priv_fault is high for exactly one cycle per refused request.
- R6: The source code register (req_sel=1) and the destination code register (req_sel=2) each store bits 2:0 of a supervisor write. A read returns the 3 bits with bits 31:3 zero.
- R7: When flag_we is high, cc_flags takes flag_in on the next edge. If the same cycle carries an accepted status write (full or condition-code), that write's flags win. A refused write does not block the flag port.
- R8: int_mask, trace_mode, super_bit and cc_flags always show the current register contents. They change on the edge after the write that alters them.
- R9: Select value 3 is unmapped. It reads as zero, writes have no effect, and it never raises priv_fault.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 2 | 0 status, 1 source code, 2 destination code, 3 unmapped |
| req_ccr_only | input | 1 | Restrict a status access to the condition-code byte |
| req_super | input | 1 | Requester runs at supervisor level |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for the current request |
| priv_fault | output | 1 | One-cycle pulse after a refused request |
| flag_we | input | 1 | ALU flag update strobe |
| flag_in | input | 5 | New X,N,Z,V,C flags |
| int_mask | output | 3 | Current interrupt priority mask |
| trace_mode | output | 2 | Current trace mode field |
| super_bit | output | 1 | Current supervisor bit |
| cc_flags | output | 5 | Current condition flags |

## Verification
On every cycle the embedded assertions check several properties. Undefined bit positions must read zero, and condition-code reads must have a clear upper byte. A refused user write must leave both code registers stable. An unopposed flag-port update must land on the next edge. Other behaviours only the bench's scenarios can show. These are the reset values, the exact packing of fields after a full write, and the priority between the flag port and a same-cycle status write. They also include the one-cycle timing of the fault pulse and the silence of the unmapped select. The bench's reference model predicts each of these and compares them every clock across directed and random request streams.

// File: rtl/ctrl_regfile.sv
module ctrl_regfile #(
  parameter int DW = 32,
  parameter int FCW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [1:0]    req_sel,
  input  logic          req_ccr_only,
  input  logic          req_super,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] rd_data,
  output logic          priv_fault,
  input  logic          flag_we,
  input  logic [4:0]    flag_in,
  output logic [2:0]    int_mask,
  output logic [1:0]    trace_mode,
  output logic          super_bit,
  output logic [4:0]    cc_flags
);
  localparam logic [1:0] SEL_SR = 2'd0, SEL_SFC = 2'd1, SEL_DFC = 2'd2;

  logic [1:0]     t_q;
  logic           s_q;
  logic [2:0]     m_q;
  logic [4:0]     f_q;
  logic [FCW-1:0] sfc_q, dfc_q;

  logic is_sr, is_fc, ccr_acc, denied, granted, wr_ok;
  logic [15:0] sr_word;

  assign is_sr   = req_valid && req_sel == SEL_SR;
  assign is_fc   = req_valid && (req_sel == SEL_SFC || req_sel == SEL_DFC);
  assign ccr_acc = is_sr && req_ccr_only;
  assign denied  = (is_fc || (is_sr && !req_ccr_only)) && !req_super;
  assign granted = (is_sr || is_fc) && !denied;
  assign wr_ok   = granted && req_write;

  assign sr_word = {t_q, s_q, 2'b00, m_q, 3'b000, f_q};

  always_comb begin
    rd_data = '0;
    if (granted && !req_write) begin
      if (ccr_acc)                rd_data[4:0]     = f_q;
      else if (is_sr)             rd_data[15:0]    = sr_word;
      else if (req_sel == SEL_SFC) rd_data[FCW-1:0] = sfc_q;
      else                        rd_data[FCW-1:0] = dfc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q <= 2'b00;
      s_q <= 1'b1;
      m_q <= 3'b111;
      f_q <= '0;
      sfc_q <= '0;
      dfc_q <= '0;
      priv_fault <= 1'b0;
    end else begin
      priv_fault <= denied;
      if (flag_we) f_q <= flag_in;
      if (wr_ok && is_sr) begin
        f_q <= req_wdata[4:0];
        if (!req_ccr_only) begin
          t_q <= req_wdata[15:14];
          s_q <= req_wdata[13];
          m_q <= req_wdata[10:8];
        end
      end
      if (wr_ok && req_sel == SEL_SFC) sfc_q <= req_wdata[FCW-1:0];
      if (wr_ok && req_sel == SEL_DFC) dfc_q <= req_wdata[FCW-1:0];
    end
  end

  assign int_mask   = m_q;
  assign trace_mode = t_q;
  assign super_bit  = s_q;
  assign cc_flags   = f_q;

  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & 32'hFFFF_18E0) == 32'h0);
  a_r4_ccr_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_sel == 2'd0 && req_ccr_only) |-> rd_data[15:8] == 8'h0);
  a_r5_user_fc_write_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !req_super && (req_sel == 2'd1 || req_sel == 2'd2))
      |=> ($stable(sfc_q) && $stable(dfc_q)));
  a_r6_fc_read_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_sel != 2'd0) |-> rd_data[31:3] == 29'h0);
  a_r7_flag_port: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && !(req_valid && req_write && req_sel == 2'd0 && (req_ccr_only || req_super)))
      |=> cc_flags == $past(flag_in));
  a_r9_unmapped_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_sel == 2'd3) |-> (rd_data == 32'h0 ##1 !priv_fault));
endmodule

// File: tb/ctrl_regfile_tb.sv
module ctrl_regfile_tb;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_ccr_only = 0, req_super = 0, flag_we = 0;
  logic [1:0] req_sel = 0;
  logic [31:0] req_wdata = 0, rd_data;
  logic [4:0] flag_in = 0, cc_flags;
  logic priv_fault, super_bit;
  logic [2:0] int_mask;
  logic [1:0] trace_mode;

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  int m_t, m_s, m_m, m_f, m_sfc, m_dfc, m_fault;

  always #5 clk = ~clk;

  ctrl_regfile u_dut (.clk, .rst_n, .req_valid, .req_write, .req_sel, .req_ccr_only,
    .req_super, .req_wdata, .rd_data, .priv_fault, .flag_we, .flag_in,
    .int_mask, .trace_mode, .super_bit, .cc_flags);

  task automatic chk(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int sr_word();
    return (m_t << 14) | (m_s << 13) | (m_m << 8) | m_f;
  endfunction

  task automatic model_reset();
    m_t = 0; m_s = 1; m_m = 7; m_f = 0; m_sfc = 0; m_dfc = 0; m_fault = 0;
  endtask

  task automatic step(bit v, bit w, int sel, bit ccr, bit sup, int wd, bit fwe, int fin);
    int exp_rd, n_f;
    bit deny, ok;
    req_valid = v; req_write = w; req_sel = sel[1:0]; req_ccr_only = ccr;
    req_super = sup; req_wdata = wd; flag_we = fwe; flag_in = fin[4:0];
    @(negedge clk);
    deny = v && ((sel == 0 && !ccr) || sel == 1 || sel == 2) && !sup;
    ok = v && sel != 3 && !deny;
    exp_rd = 0;
    if (ok && !w) begin
      if (sel == 0) exp_rd = ccr ? m_f : sr_word();
      else exp_rd = (sel == 1) ? m_sfc : m_dfc;
    end
    chk(sel == 3 ? "R9 rd_data" : (deny ? "R5 rd_data" : "R2/R4/R6 rd_data"), rd_data, exp_rd);
    chk("R5 priv_fault", priv_fault, m_fault);
    chk("R8 int_mask", int_mask, m_m);
    chk("R8 trace_mode", trace_mode, m_t);
    chk("R8 super_bit", super_bit, m_s);
    chk("R7 cc_flags", cc_flags, m_f);
    n_f = fwe ? fin : m_f;
    @(posedge clk);
    #1;
    m_fault = deny;
    m_f = n_f;
    if (ok && w) begin
      if (sel == 0) begin
        m_f = wd & 'h1F;
        if (!ccr) begin
          m_t = (wd >> 14) & 3; m_s = (wd >> 13) & 1; m_m = (wd >> 8) & 7;
        end
      end else if (sel == 1) m_sfc = wd & 7;
      else m_dfc = wd & 7;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    model_reset();
    @(negedge clk);
    chk("R1 super_bit", super_bit, 1);
    chk("R1 int_mask", int_mask, 7);
    chk("R1 trace_mode", trace_mode, 0);
    chk("R1 cc_flags", cc_flags, 0);
    @(posedge clk); #1 rst_n = 1;
    step(1, 0, 0, 0, 1, 0, 0, 0);                 // R1 status after reset reads 0x2700
    step(1, 0, 1, 0, 1, 0, 0, 0);                 // R1 sfc zero
    step(1, 1, 0, 0, 1, 'hFFFF_FFFF, 0, 0);       // R2 R3 full write
    step(1, 0, 0, 0, 1, 0, 0, 0);                 // expect 0xE71F
    step(1, 1, 0, 1, 0, 'hFFFF_A5EA, 0, 0);       // R4 user ccr write keeps upper
    step(1, 0, 0, 1, 0, 0, 0, 0);                 // R4 ccr read
    step(1, 1, 0, 0, 0, 'h0000_0000, 0, 0);       // R5 user full write refused
    step(1, 0, 0, 0, 1, 0, 0, 0);
    step(1, 1, 1, 0, 1, 'hFFFF_FFFD, 0, 0);       // R6 sfc = 5
    step(1, 1, 2, 0, 1, 'h0000_000A, 0, 0);       // R6 dfc = 2
    step(1, 0, 1, 0, 1, 0, 0, 0);
    step(1, 0, 2, 0, 1, 0, 0, 0);
    step(1, 1, 1, 0, 0, 'h7, 0, 0);               // R5 user fc write refused
    step(1, 0, 2, 0, 0, 0, 0, 0);                 // R5 user fc read refused
    step(1, 0, 1, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1, 'h15);              // R7 flag port alone
    step(1, 1, 0, 1, 0, 'h3, 1, 'h1C);            // R7 write wins
    step(1, 1, 0, 0, 0, 'h0, 1, 'h0E);            // R7 refused write does not block
    step(1, 1, 3, 0, 0, 'hFFFF, 0, 0);            // R9 unmapped write
    step(1, 0, 3, 0, 1, 0, 0, 0);                 // R9 unmapped read
    step(0, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 400; i++)
      step($urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom_range(0, 3),
           $urandom_range(0, 1), $urandom_range(0, 2) != 0, $urandom,
           $urandom_range(0, 2) == 0, $urandom_range(0, 31));
    rst_n = 0; model_reset();
    @(negedge clk);
    chk("R1 super_bit again", super_bit, 1);
    chk("R1 int_mask again", int_mask, 7);
    chk("R1 cc_flags again", cc_flags, 0);
    finish_run();
  end
endmodule